// File: doc/BRIEF.md
# Host Port Halfword Register Bridge

This block connects a 16-bit external host bus to three 32-bit internal registers: a control register, an address register and a data register. Every register access from the host is made of two halfword strobes. The block joins two halfwords into one 32-bit word when the host writes, and splits a word into two halfwords when the host reads. Bit 0 of the control register chooses which of the two halfwords carries the upper bits of the word.

The data register stands in front of a single-word memory port that uses a request/acknowledge handshake. When the second halfword of a data write is captured, the block sends one write request. When the host asks for the first halfword of a data read, the block sends one read request. The second halfword of a read comes from the word already fetched. Of the two data access codes, one advances the address register by one 32-bit word once the transfer completes. The other leaves the address register as it is.

Top module: `hpb_bridge`

## Requirements
- R1: After reset the control, address and data registers hold zero, `mem_req` is low and `host_rdata` is zero.
- R2: `host_sel` picks the target. 0 selects control, 1 selects address, 2 selects data with post-increment and 3 selects data without any address change.
- R3: `host_second` is 0 for the first halfword and 1 for the second. With control bit 0 clear, the first halfword is bits 31:16 and the second is bits 15:0. With the bit set, the first halfword is bits 15:0 and the second is bits 31:16. This holds for reads and for writes.
- R4: Writing only the first halfword does not change a register. A register is updated only when its second halfword is written.
- R5: When the second halfword of a data write is captured, the block raises exactly one request with `mem_we`=1. The request carries the assembled word and the address register with bits 1:0 forced to 0.
- R6: With code 2, the address register grows by 4 in the cycle the write request is acknowledged. With code 3, the address register does not change.
- R7: A first-halfword data read raises one request with `mem_we`=0. The first halfword of the returned word appears on `host_rdata` in the cycle after the acknowledge. The second-halfword read raises no request, and with code 2 it adds 4 to the address register.
- R8: `mem_req` and its address, data and direction stay steady until `mem_ack`. `mem_req` drops in the cycle after the acknowledge, and each transfer makes exactly one request.
- R9: A data strobe (code 2 or 3) that arrives while a request is outstanding is ignored. It raises no new request and does not change the data register.
- R10: A host write of the second address halfword can complete in the same cycle as the acknowledge of a code-2 write. In that case the host value goes into the address register and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strobe | input | 1 | One-cycle pulse per halfword access |
| host_sel | input | 2 | Target and address-update code |
| host_second | input | 1 | 0 for first halfword, 1 for second |
| host_rd | input | 1 | 1 for read, 0 for write |
| host_wdata | input | 16 | Halfword written by the host |
| host_rdata | output | 16 | Halfword returned to the host |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 32 | Word read from memory, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted or completed |

## Verification
Two updates to the address register can fall into one cycle. One is the post-increment that fires when a code-2 write is acknowledged. The other is a host write completing the second address halfword. To provoke the clash, the bench switches its memory model to manual acknowledge and starts a code-2 write. It then times the last address strobe so that it is sampled on the same edge as the acknowledge. Reading the address register back must give the host value with no 4 added, and the scoreboard must still see exactly one write request.

// File: rtl/hpb_pkg.sv
// Package hpb_pkg: shared types for the host port halfword bridge.
// Assumes a 2-bit function code on the host side.
package hpb_pkg;
    typedef enum logic [1:0] {
        FN_CTRL     = 2'd0,
        FN_ADDR     = 2'd1,
        FN_DATA_INC = 2'd2,
        FN_DATA_FIX = 2'd3
    } host_fn_e;
endpackage

// File: rtl/hpb_hw_order.sv
// Module hpb_hw_order: places halfwords within a word according to the order bit.
// Joins a first and second halfword into a word, and picks one halfword of a word.
// Purely combinational; assumes order_i is stable while the result is used.
module hpb_hw_order #(
    parameter int HW_W = 16
) (
    input  logic                order_i,
    input  logic [HW_W-1:0]     first_i,
    input  logic [HW_W-1:0]     second_i,
    input  logic [2*HW_W-1:0]   word_i,
    input  logic                pick_second_i,
    output logic [2*HW_W-1:0]   word_o,
    output logic [HW_W-1:0]     half_o
);
    // Join: order 0 puts the first halfword on top, order 1 puts it at the bottom.
    always_comb begin
        if (order_i) word_o = {second_i, first_i};
        else         word_o = {first_i, second_i};
    end

    // Split: the low half is wanted when exactly one of order and pick is set.
    always_comb begin
        if (pick_second_i ^ order_i) half_o = word_i[HW_W-1:0];
        else                         half_o = word_i[2*HW_W-1:HW_W];
    end
endmodule

// File: rtl/hpb_mem_port.sv
// Module hpb_mem_port: single-outstanding request/acknowledge memory port.
// Latches direction, address and write data when a request is issued and
// holds them until the acknowledge arrives. Assumes issue_i comes only while idle.
module hpb_mem_port #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              issue_we_i,
    input  logic [WORD_W-1:0] issue_addr_i,
    input  logic [WORD_W-1:0] issue_wdata_i,
    input  logic              mem_ack_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              req_q;
    logic              we_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    // Request state: set on issue, cleared on the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_q && mem_ack_i) begin
            req_q <= 1'b0;
        end else if (issue_i && !req_q) begin
            req_q   <= 1'b1;
            we_q    <= issue_we_i;
            addr_q  <= issue_addr_i;
            wdata_q <= issue_wdata_i;
        end
    end

    assign mem_req_o   = req_q;
    assign mem_we_o    = we_q;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = wdata_q;
    assign busy_o      = req_q;
    assign done_o      = req_q && mem_ack_i;

    // R8: request and its fields stay steady until acknowledged.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8: request drops in the cycle after the acknowledge.
    a_r8_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> !mem_req_o);
endmodule

// File: rtl/hpb_bridge.sv
// Module hpb_bridge: host halfword bus to control/address/data registers,
// with a single-word memory port behind the data register.
// Assumes one strobe per halfword. The host waits for a data transfer to finish
// before its next data strobe; data strobes during a request are dropped.
module hpb_bridge #(
    parameter int HW_W      = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_strobe,
    input  logic [1:0]          host_sel,
    input  logic                host_second,
    input  logic                host_rd,
    input  logic [HW_W-1:0]     host_wdata,
    output logic [HW_W-1:0]     host_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [2*HW_W-1:0]   mem_addr,
    output logic [2*HW_W-1:0]   mem_wdata,
    input  logic [2*HW_W-1:0]   mem_rdata,
    input  logic                mem_ack
);
    import hpb_pkg::*;

    localparam int WORD_W     = 2 * HW_W;
    localparam int ALIGN_BITS = $clog2(ADDR_STEP);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(ADDR_STEP);

    host_fn_e          fn;
    logic              fn_data;
    logic              busy;
    logic              done;
    logic              hit;
    logic              wr_done;
    logic              rd_second_inc;
    logic              issue;
    logic              inc_pend_q;
    logic [HW_W-1:0]   first_q;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] asm_word;
    logic [WORD_W-1:0] rd_src;
    logic              rd_pick;
    logic              rd_load;
    logic [HW_W-1:0]   rd_half;
    logic [HW_W-1:0]   rdata_q;
    logic [WORD_W-1:0] issue_addr;
    logic              addr_host_wr;
    logic              inc_now;

    assign fn      = host_fn_e'(host_sel);
    assign fn_data = host_sel[1];
    assign hit     = host_strobe && !(fn_data && busy);
    assign wr_done = hit && !host_rd && host_second;
    assign rd_second_inc = hit && host_rd && host_second && (fn == FN_DATA_INC);
    assign issue   = (wr_done && fn_data) || (hit && host_rd && !host_second && fn_data);
    assign issue_addr = {addr_q[WORD_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
    assign addr_host_wr = wr_done && (fn == FN_ADDR);
    assign inc_now = (done && inc_pend_q) || rd_second_inc;

    hpb_hw_order #(.HW_W(HW_W)) order_i (
        .order_i       (ctrl_q[0]),
        .first_i       (first_q),
        .second_i      (host_wdata),
        .word_i        (rd_src),
        .pick_second_i (rd_pick),
        .word_o        (asm_word),
        .half_o        (rd_half)
    );

    hpb_mem_port #(.WORD_W(WORD_W)) port_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_i       (issue),
        .issue_we_i    (!host_rd),
        .issue_addr_i  (issue_addr),
        .issue_wdata_i (asm_word),
        .mem_ack_i     (mem_ack),
        .mem_req_o     (mem_req),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .busy_o        (busy),
        .done_o        (done)
    );

    // Holds the first halfword of a write until the second one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                                first_q <= '0;
        else if (hit && !host_rd && !host_second)  first_q <= host_wdata;
    end

    // Control register: written only on a completed two-halfword write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (wr_done && fn == FN_CTRL)   ctrl_q <= asm_word;
    end

    // Address register: a host write wins over the post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n)            addr_q <= '0;
        else if (addr_host_wr) addr_q <= asm_word;
        else if (inc_now)      addr_q <= addr_q + STEP;
    end

    // Remembers that the outstanding write asked for a post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                      inc_pend_q <= 1'b0;
        else if (done)                   inc_pend_q <= 1'b0;
        else if (issue && !host_rd)      inc_pend_q <= (fn == FN_DATA_INC);
    end

    // Data register: loaded by a host write or by a returned read word.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (wr_done && fn_data) data_q <= asm_word;
        else if (done && !mem_we)   data_q <= mem_rdata;
    end

    // Chooses which word and halfword feed the read-back register.
    always_comb begin
        rd_src  = data_q;
        rd_pick = host_second;
        if (done && !mem_we) begin
            rd_src  = mem_rdata;
            rd_pick = 1'b0;
        end else begin
            case (fn)
                FN_CTRL: rd_src = ctrl_q;
                FN_ADDR: rd_src = addr_q;
                default: rd_src = data_q;
            endcase
        end
    end

    assign rd_load = (done && !mem_we) || (hit && host_rd && (!fn_data || host_second));

    // Read-back register presented to the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_load) rdata_q <= rd_half;
    end

    assign host_rdata = rdata_q;

    // R4: a lone first halfword leaves the control register alone.
    a_r4_ctrl_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && !host_rd && !host_second && host_sel == 2'd0) |=> $stable(ctrl_q));

    // R6: an acknowledged code-2 write with no host address write advances by one word.
    a_r6_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inc_pend_q && !addr_host_wr) |=> (addr_q == $past(addr_q) + STEP));

    // R9: a data strobe during an outstanding request leaves the data register unchanged.
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && host_strobe && host_sel[1]) |=> $stable(data_q));

    // R7: the second halfword of a data read starts no memory request.
    a_r7_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && host_rd && host_second && host_sel[1] && !mem_req) |=> !mem_req);
endmodule

// File: tb/hpb_bridge_tb.sv
// Bench hpb_bridge_tb_top: scoreboard bench for hpb_bridge with a memory model.
module hpb_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_strobe = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_second = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    logic        manual_ack = 1'b0;
    logic        ack_kick = 1'b0;
    logic [31:0] mem_arr [16];
    int          ack_cnt;

    int vectors = 0;
    int fails   = 0;
    int mon_vec = 0;
    int mon_bad = 0;
    logic [64:0] exp_q [$];

    logic        ord = 1'b0;
    logic [31:0] maddr = 32'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .host_sel(host_sel),
        .host_second(host_second), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    assign mem_rdata = mem_arr[mem_addr[5:2]];

    // Memory model: fixed latency or acknowledge on a bench kick.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            ack_cnt <= 0;
            for (int i = 0; i < 16; i++) mem_arr[i] <= 32'd0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            ack_cnt <= 0;
            if (mem_we) mem_arr[mem_addr[5:2]] <= mem_wdata;
        end else if (mem_req) begin
            if (manual_ack) begin
                if (ack_kick) mem_ack <= 1'b1;
            end else if (ack_cnt == LAT) begin
                mem_ack <= 1'b1;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end
    end

    // Monitor: every accepted request is popped and compared (R5, R7, R8).
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            mon_vec++;
            if (exp_q.size() == 0) begin
                mon_bad++;
                $display("FAIL R8 unexpected request: we=%0b addr=%h, expected none", mem_we, mem_addr);
            end else begin
                logic [64:0] e;
                e = exp_q.pop_front();
                if (mem_we !== e[64] || mem_addr !== e[63:32] || (e[64] && mem_wdata !== e[31:0])) begin
                    mon_bad++;
                    $display("FAIL R5/R7 request: we=%0b addr=%h data=%h, expected we=%0b addr=%h data=%h",
                             mem_we, mem_addr, mem_wdata, e[64], e[63:32], e[31:0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec + 1, fails + mon_bad + 1);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe_hw(input logic [1:0] sel, input logic sec, input logic rd, input logic [15:0] wd);
        @(negedge clk);
        host_strobe = 1'b1; host_sel = sel; host_second = sec; host_rd = rd; host_wdata = wd;
        @(negedge clk);
        host_strobe = 1'b0;
    endtask

    task automatic wait_idle;
        while (mem_req) @(negedge clk);
    endtask

    task automatic put_word(input logic [1:0] sel, input logic [31:0] w);
        logic [15:0] f, s;
        f = ord ? w[15:0] : w[31:16];
        s = ord ? w[31:16] : w[15:0];
        strobe_hw(sel, 1'b0, 1'b0, f);
        if (sel[1]) exp_q.push_back({1'b1, maddr[31:2], 2'b00, w});
        strobe_hw(sel, 1'b1, 1'b0, s);
        if (sel[1]) wait_idle();
    endtask

    task automatic get_word(input logic [1:0] sel, input logic [31:0] expm, output logic [31:0] w);
        logic [15:0] h1, h2;
        if (sel[1]) exp_q.push_back({1'b0, maddr[31:2], 2'b00, expm});
        strobe_hw(sel, 1'b0, 1'b1, 16'd0);
        if (sel[1]) wait_idle();
        h1 = host_rdata;
        strobe_hw(sel, 1'b1, 1'b1, 16'd0);
        h2 = host_rdata;
        w = ord ? {h2, h1} : {h1, h2};
    endtask

    initial begin
        logic [31:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 rdata", {16'd0, host_rdata}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        get_word(2'd0, 32'd0, w); chk("R1 ctrl", w, 32'd0);
        get_word(2'd1, 32'd0, w); chk("R1 addr", w, 32'd0);

        // R2, R3: address write and read-back, order 0.
        put_word(2'd1, 32'h0000_0010); maddr = 32'h10;
        get_word(2'd1, 32'd0, w); chk("R2 addr readback", w, 32'h10);

        // R4: first halfword alone changes nothing.
        strobe_hw(2'd1, 1'b0, 1'b0, 16'hAAAA);
        get_word(2'd1, 32'd0, w); chk("R4 addr unchanged", w, 32'h10);
        strobe_hw(2'd0, 1'b0, 1'b0, 16'hFFFF);
        get_word(2'd0, 32'd0, w); chk("R4 ctrl unchanged", w, 32'd0);

        // R5, R6: code 3 write, address unchanged.
        put_word(2'd3, 32'h1234_5678);
        get_word(2'd1, 32'd0, w); chk("R6 code3 no inc", w, 32'h10);
        // R6: code 2 write, address advances.
        put_word(2'd2, 32'h9ABC_DEF0); maddr = 32'h14;
        get_word(2'd1, 32'd0, w); chk("R6 code2 inc", w, 32'h14);

        // R3: flip order, check raw first halfword is the low half.
        put_word(2'd0, 32'h0000_0001); ord = 1'b1;
        get_word(2'd0, 32'd0, w); chk("R3 ctrl order1", w, 32'h1);
        strobe_hw(2'd0, 1'b0, 1'b1, 16'd0);
        chk("R3 first half is low half", {16'd0, host_rdata}, 32'h0001);
        put_word(2'd2, 32'hCAFE_BEEF); maddr = 32'h18;

        // R5: unaligned address gives word-aligned request.
        put_word(2'd1, 32'h0000_0023); maddr = 32'h23;
        put_word(2'd3, 32'h55AA_0FF0);
        get_word(2'd1, 32'd0, w); chk("R5 addr kept", w, 32'h23);

        // R7: code 2 read, one request, then post-increment.
        get_word(2'd2, 32'h55AA_0FF0, w); chk("R7 read word", w, 32'h55AA_0FF0);
        maddr = 32'h27;
        get_word(2'd1, 32'd0, w); chk("R7 inc after read", w, 32'h27);
        // R7: code 3 read with order 0, address stays.
        put_word(2'd0, 32'h0000_0000); ord = 1'b0;
        put_word(2'd1, 32'h0000_0014); maddr = 32'h14;
        get_word(2'd3, 32'hCAFE_BEEF, w); chk("R7 code3 read", w, 32'hCAFE_BEEF);
        get_word(2'd1, 32'd0, w); chk("R7 code3 no inc", w, 32'h14);

        // R9: data strobes during an outstanding write are dropped.
        put_word(2'd1, 32'h0000_0030); maddr = 32'h30;
        manual_ack = 1'b1;
        strobe_hw(2'd3, 1'b0, 1'b0, 16'h2222);
        exp_q.push_back({1'b1, 32'h30, 32'h2222_1111});
        strobe_hw(2'd3, 1'b1, 1'b0, 16'h1111);
        strobe_hw(2'd3, 1'b0, 1'b1, 16'd0);
        strobe_hw(2'd3, 1'b1, 1'b0, 16'h7777);
        chk("R9 req still held", {31'd0, mem_req}, 32'd1);
        chk("R8 addr held", mem_addr, 32'h30);
        chk("R9 wdata held", mem_wdata, 32'h2222_1111);
        @(negedge clk); ack_kick = 1'b1;
        @(negedge clk); ack_kick = 1'b0;
        wait_idle();
        manual_ack = 1'b0;
        get_word(2'd3, 32'h2222_1111, w); chk("R9 stored word", w, 32'h2222_1111);

        // R10: host address write lands on the acknowledge of a code-2 write.
        manual_ack = 1'b1;
        strobe_hw(2'd2, 1'b0, 1'b0, 16'h0BAD);
        exp_q.push_back({1'b1, 32'h30, 32'h0BAD_0DAD});
        strobe_hw(2'd2, 1'b1, 1'b0, 16'h0DAD);
        strobe_hw(2'd1, 1'b0, 1'b0, 16'h0000);
        @(negedge clk); ack_kick = 1'b1;
        @(negedge clk); ack_kick = 1'b0;
        host_strobe = 1'b1; host_sel = 2'd1; host_second = 1'b1; host_rd = 1'b0; host_wdata = 16'h0040;
        @(negedge clk); host_strobe = 1'b0;
        wait_idle();
        manual_ack = 1'b0;
        maddr = 32'h40;
        get_word(2'd1, 32'd0, w); chk("R10 host write wins", w, 32'h40);

        repeat (4) @(negedge clk);
        chk("R8 all requests seen", exp_q.size(), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec, fails + mon_bad);
        $finish;
    end
endmodule